// File: doc/BRIEF.md
# Post-PLL Divider Bank with Staged Ratio Commit

This block takes one fast clock that comes out of a PLL and produces several slower clock-enable streams from it. Each stream is set by its own divider register, which holds a division ratio and an enable flag. Software writes to these registers only stage a new setting. Nothing changes at the outputs until software issues a commit command. The commit loads every staged ratio into the active dividers at the same moment and restarts all of their counts on that edge.

A status flag shows that a commit is still settling. Software polls it before and after each commit. A parameter can tie any divider to the raw reference instead of the PLL output. That divider then counts reference pulses, which arrive as a one-cycle strobe (`ref_en`) in the fast clock domain. Each output `tick_o[i]` is a one-cycle pulse, and it can drive the clock enable of a downstream domain.

Register map, with `AW=4`:
- Addresses 0 to NDIV-1 are the divider registers. Bits [RW-1:0] hold the ratio and bit DW-1 is the enable flag.
- Address 14 is the command register. Writing bit 0 as 1 issues a commit.
- Address 15 is the status register. Bit 0 is the busy flag.

Top module: `pll_div_bank`

## Requirements
- R1: With its enable bit set, a divider whose active ratio field holds N pulses `tick_o` once every N+1 source events. A field value of 0 therefore divides by 1.
- R2: With its enable bit clear, a divider pulses on every source event, whatever its ratio field holds.
- R3: A write to a divider register changes no output until a commit is issued.
- R4: A commit is a write to address 14 with bit 0 set while the block is not busy. It loads all staged settings at that edge and restarts every divider count on that edge. After the commit, the first pulse of a divide-by-(N+1) divider falls on the (N+1)th source event.
- R5: Status bit 0 reads 1 for exactly GO_CYCLES (default 8) clock cycles, starting in the cycle after the commit write.
- R6: A divider write while busy is accepted into staging but does not change the active dividers. A commit write while busy is ignored.
- R7: A divider marked as reference-sourced (PRE_MASK bit set; by default divider 2) counts only cycles with `ref_en` high, and it pulses only in such cycles.
- R8: Reading a divider register returns its staged value: ratio in bits [RW-1:0] (RW=5), enable in bit 15, and every other bit 0. Written bits outside those fields are dropped.
- R9: After reset, all staged and active settings are zero, busy is 0, and every divider divides by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the PLL |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle strobe per reference clock period |
| we | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data (combinational) |
| tick_o | output | NDIV | Per-divider output pulse |

## Verification
The assertions check four things on every cycle:
- A commit write made while idle raises busy.
- Busy stays high for exactly the configured number of cycles.
- The active ratios hold steady for the whole busy window.
- Status reads mirror busy, and reference-sourced dividers never pulse without a reference strobe.

Other behaviours can only be shown by the bench scenarios, because they depend on the pulse pattern over many cycles. These are:
- the actual division factors;
- the common restart of all counts at a commit;
- the pass-through of a disabled divider;
- the fact that staged writes and busy-time commits leave the outputs alone;
- the masking of readback fields.

// File: rtl/pll_div_bank.sv
module pll_div_bank #(
  parameter int NDIV = 3,
  parameter int RW = 5,
  parameter int GO_CYCLES = 8,
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [NDIV-1:0] PRE_MASK = 3'b100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NDIV-1:0] tick_o
);
  localparam logic [AW-1:0] CMD_ADDR  = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] STAT_ADDR = AW'((1 << AW) - 1);
  localparam int EN_BIT = DW - 1;
  localparam int BW = $clog2(GO_CYCLES + 1);

  logic [NDIV-1:0][RW-1:0] stg_ratio;
  logic [NDIV-1:0]         stg_en;
  logic [NDIV-1:0][RW-1:0] act_div;
  logic [NDIV-1:0][RW-1:0] cnt;
  logic                    busy;
  logic [BW-1:0]           bcnt;
  logic [NDIV-1:0]         ev;

  wire go_fire = we && (addr == CMD_ADDR) && wdata[0] && !busy;

  logic unused_wbits;
  assign unused_wbits = &{1'b0, wdata[DW-2:RW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_ratio <= '0;
      stg_en    <= '0;
    end else if (we) begin
      for (int i = 0; i < NDIV; i++) begin
        if (addr == AW'(i)) begin
          stg_ratio[i] <= wdata[RW-1:0];
          stg_en[i]    <= wdata[EN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bcnt <= '0;
    end else if (go_fire) begin
      busy <= 1'b1;
      bcnt <= '0;
    end else if (busy) begin
      if (bcnt == BW'(GO_CYCLES - 1)) busy <= 1'b0;
      else bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
    end else if (go_fire) begin
      for (int i = 0; i < NDIV; i++)
        act_div[i] <= stg_en[i] ? stg_ratio[i] : '0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NDIV; g++) begin : g_div
      if (PRE_MASK[g]) begin : g_ref
        assign ev[g] = ref_en;
      end else begin : g_pll
        assign ev[g] = 1'b1;
      end

      assign tick_o[g] = ev[g] && (cnt[g] == act_div[g]);

      always_ff @(posedge clk) begin
        if (!rst_n || go_fire) cnt[g] <= '0;
        else if (ev[g]) cnt[g] <= (cnt[g] == act_div[g]) ? '0 : cnt[g] + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDIV; i++) begin
      if (addr == AW'(i)) begin
        rdata[RW-1:0] = stg_ratio[i];
        rdata[EN_BIT] = stg_en[i];
      end
    end
    if (addr == STAT_ADDR) rdata[0] = busy;
  end
endmodule

// File: rtl/pll_div_bank_chk.sv
module pll_div_bank_chk #(
  parameter int NDIV = 3,
  parameter int RW = 5,
  parameter int GO_CYCLES = 8,
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [NDIV-1:0] PRE_MASK = 3'b100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_en,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          busy,
  input logic [NDIV-1:0][RW-1:0] act_div,
  input logic [NDIV-1:0] tick_o
);
  localparam logic [AW-1:0] CMD_ADDR  = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] STAT_ADDR = AW'((1 << AW) - 1);

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata[DW-1:1], rdata[DW-1:1]};

  logic [15:0] hcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) hcnt <= '0;
    else hcnt <= hcnt + 16'd1;
  end

  // R4
  go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CMD_ADDR && wdata[0] && !busy) |=> busy);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (hcnt == 16'(GO_CYCLES)));

  // R5
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR) |-> (rdata[0] == busy));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_div));

  genvar g;
  generate
    for (g = 0; g < NDIV; g++) begin : g_pre
      if (PRE_MASK[g]) begin : g_on
        // R7
        pre_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
          tick_o[g] |-> ref_en);
      end
    end
  endgenerate
endmodule

bind pll_div_bank pll_div_bank_chk #(
  .NDIV(NDIV), .RW(RW), .GO_CYCLES(GO_CYCLES), .AW(AW), .DW(DW), .PRE_MASK(PRE_MASK)
) u_chk (.*);

// File: tb/test_pll_div_bank.sv
module test_pll_div_bank;
  localparam int NDIV = 3;
  localparam logic [3:0] CMD = 4'd14;
  localparam logic [3:0] STAT = 4'd15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = STAT;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NDIV-1:0] tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string phase = "R1";

  logic [4:0] sbq[$];

  always #4 clk = ~clk;

  pll_div_bank i_pll_div_bank (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      logic [4:0] it;
      it = sbq.pop_front();
      chk({phase, " R1 tick0"}, 16'(tick_o[0]), 16'(it[0]));
      chk({phase, " R2 tick1"}, 16'(tick_o[1]), 16'(it[1]));
      chk({phase, " R7 tick2"}, 16'(tick_o[2]), 16'(it[2]));
      if (it[4]) chk({phase, " R5 busy"}, 16'(rdata[0]), 16'(it[3]));
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = STAT; wdata = '0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [15:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
    addr = STAT;
  endtask

  // Commit, then drive/score n cycles. f0,f1 on PLL; f2 on reference (strobe every 3rd cycle).
  task automatic go_run(int f0, int f1, int f2, int n, bit mid);
    int refs;
    refs = 0;
    @(posedge clk); #1;
    we = 1'b1; addr = CMD; wdata = 16'h0001;
    for (int k = 0; k < n; k++) begin
      logic [4:0] it;
      @(posedge clk); #1;
      we = 1'b0; addr = STAT; wdata = '0;
      ref_en = (k % 3 == 0);
      if (mid && k == 2) begin we = 1'b1; addr = 4'd0; wdata = 16'h8000; end
      if (mid && k == 3) begin we = 1'b1; addr = CMD; wdata = 16'h0001; end
      it[0] = ((k + 1) % f0 == 0);
      it[1] = ((k + 1) % f1 == 0);
      if (ref_en) refs++;
      it[2] = ref_en && (refs % f2 == 0);
      it[3] = (k < 8);
      it[4] = (addr == STAT);
      sbq.push_back(it);
    end
    @(posedge clk); #1;
    we = 1'b0; addr = STAT; ref_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    rd("R9 div0", 4'd0, 16'h0000);
    rd("R9 div2", 4'd2, 16'h0000);
    rd("R9 busy", STAT, 16'h0000);
    @(negedge clk);
    chk("R9 ticks no ref", 16'(tick_o), 16'h0003);
    ref_en = 1'b1;
    @(negedge clk);
    chk("R9 ticks ref", 16'(tick_o), 16'h0007);
    ref_en = 1'b0;

    // R8 masking of readback, enable clear
    wr(4'd1, 16'h7FFF);
    rd("R8 mask", 4'd1, 16'h001F);
    wr(4'd0, 16'hFFE2);
    rd("R8 staged div0", 4'd0, 16'h8002);
    wr(4'd1, 16'h0003);
    wr(4'd2, 16'h8001);
    // R3 staging only
    @(negedge clk);
    chk("R3 no effect", 16'(tick_o), 16'h0003);
    rd("R3 busy idle", STAT, 16'h0000);

    // R4 commit: div0 /3, div1 disabled -> /1 (R2), div2 /2 on reference (R7); R6 mid writes
    phase = "R4";
    go_run(3, 1, 2, 24, 1'b1);
    rd("R6 staged while busy", 4'd0, 16'h8000);

    // R6 second commit now takes the write made during busy
    phase = "R6";
    go_run(1, 1, 2, 12, 1'b0);

    wr(4'd0, 16'h8004);
    wr(4'd1, 16'h8001);
    phase = "R1";
    go_run(5, 2, 2, 20, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule